// File: doc/BRIEF.md
# Encoder Position Counter with Range Wrap and Sticky Wrap Flags

This block keeps the 32-bit position of an incremental encoder. An upstream quadrature decoder supplies one-cycle count-up and count-down strobes. The counter steps by one on each strobe. It can run in one of two modes:

- **Free mode:** the counter wraps naturally across the full 32-bit range.
- **Range mode:** the counter is held between a programmable lower bound (`lo_bound`) and upper bound (`hi_bound`).

Each wrap in either direction raises a sticky flag. Software clears a flag with a write-one-to-clear pulse. The flags, each gated by its own enable, are ORed with an external index interrupt to drive one interrupt line. A last-direction bit records the direction of the most recent count.

A signed companion counter, `pos_delta`, follows the net number of counts. When enabled, a synchronized rising edge on an asynchronous trigger input clears both `pos` and `pos_delta`.

Top module: `enc_pos_counter`

## Requirements
- R1: In range mode (`range_en`=1), an up count while `pos` equals `hi_bound` loads `lo_bound` into `pos`. Any other up count adds 1.
- R2: In range mode, a down count while `pos` equals `lo_bound` loads `hi_bound` into `pos`. Any other down count subtracts 1.
- R3: In free mode (`range_en`=0), the bounds have no effect. An up count from 0xFFFFFFFF gives 0, and a down count from 0 gives 0xFFFFFFFF.
- R4: `over_flag` is set in the cycle after one of these events:
  - an up-count reload from `hi_bound` to `lo_bound`;
  - an up count from 0xFFFFFFFF.

  It then stays set until an `over_clr` pulse with no new roll-over in the same cycle.
- R5: `under_flag` is set in the cycle after one of these events:
  - a down-count reload from `lo_bound` to `hi_bound`;
  - a down count from 0.

  It then stays set until an `under_clr` pulse with no new roll-under in the same cycle.
- R6: `irq` is a combinational function: (`over_flag` AND `over_ie`) OR (`under_flag` AND `under_ie`) OR `index_irq`.
- R7: `dir_up` becomes 1 after an up count and 0 after a down count. It reads 0 after reset.
- R8: When `cnt_up` and `cnt_dn` are both high in the same cycle, they cancel. `pos`, `pos_delta` and `dir_up` keep their values.
- R9: When `trig_clr_en`=1, a rising edge of `trig_in` clears `pos` and `pos_delta` at the third clock edge after the edge is sampled.
  - This clear overrides a count strobe in the same cycle.
  - A level held high clears only once.
  - When `trig_clr_en`=0, the trigger has no effect.
- R10: If a flag is set by hardware and cleared by software in the same cycle, the flag stays set.
- R11: `pos_delta` is a two's-complement count that adds 1 per up count and subtracts 1 per down count. Only reset or an enabled trigger clears it.
- R12: A synchronous reset clears `pos`, `pos_delta`, `dir_up` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | 1 | One-cycle up-count strobe |
| cnt_dn | input | 1 | One-cycle down-count strobe |
| range_en | input | 1 | 1 selects range mode, 0 selects free mode |
| lo_bound | input | 32 | Lower bound; reload value on roll-over |
| hi_bound | input | 32 | Upper bound; reload value on roll-under |
| trig_clr_en | input | 1 | Allows the trigger edge to clear the counters |
| trig_in | input | 1 | Asynchronous trigger input |
| over_ie | input | 1 | Roll-over interrupt enable |
| under_ie | input | 1 | Roll-under interrupt enable |
| over_clr | input | 1 | Write-one-to-clear pulse for `over_flag` |
| under_clr | input | 1 | Write-one-to-clear pulse for `under_flag` |
| index_irq | input | 1 | External index interrupt, merged into `irq` |
| pos | output | 32 | Position counter |
| pos_delta | output | 32 | Signed net-count counter |
| dir_up | output | 1 | Direction of the last count (1 = up) |
| over_flag | output | 1 | Sticky roll-over flag |
| under_flag | output | 1 | Sticky roll-under flag |
| irq | output | 1 | Merged interrupt output |

## Verification
Count strobes and clear pulses take effect at the next rising edge. The bench therefore drives them at a falling edge and reads `pos`, `pos_delta`, `dir_up` and the flags at the following falling edge. `irq` is combinational, so it is checked in the same half cycle as the flag or enable change that causes it. The trigger passes through two synchronizer flops and an edge detector, so its clear lands on the third rising edge. The bench checks that `pos` is still counting after two edges and is zero after the third. Range-mode wraps are reached by counting step by step from a known position, so every expected value follows from the requirements alone.

// File: rtl/enc_pos_pkg.sv
package enc_pos_pkg;

    // Kind of count step requested in the current cycle
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    // Wrap events produced by one count step
    typedef struct packed {
        logic over;
        logic under;
    } wrap_evt_t;

    localparam int NUM_WRAP = 2;
    localparam int WRAP_OVER  = 1;
    localparam int WRAP_UNDER = 0;

    // Up and down strobes together cancel each other
    function automatic step_e decode_step(input logic up, input logic dn);
        if (up && !dn)
            return STEP_INC;
        else if (dn && !up)
            return STEP_DEC;
        else
            return STEP_IDLE;
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    input  logic enable,
    output logic fire
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Synchronizer chain: stage 0 samples the pin, each later stage samples the one before
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign fire = enable && chain[STAGES-1] && !last_q;

endmodule

// File: rtl/pos_core.sv
module pos_core
    import enc_pos_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    input  logic             clr,
    input  logic             range_en,
    input  logic [POS_W-1:0] lo_bound,
    input  logic [POS_W-1:0] hi_bound,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] delta,
    output logic             dir_up,
    output wrap_evt_t        evt
);
    localparam logic [POS_W-1:0] ALL_ONES = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] ONE      = {{(POS_W-1){1'b0}}, 1'b1};

    logic [POS_W-1:0] pos_nxt;
    wrap_evt_t        raw_evt;

    always_comb begin
        pos_nxt = pos;
        raw_evt = '0;
        unique case (step)
            STEP_INC: begin
                if (range_en && pos == hi_bound) begin
                    pos_nxt      = lo_bound;
                    raw_evt.over = 1'b1;
                end else begin
                    pos_nxt      = pos + ONE;
                    raw_evt.over = (pos == ALL_ONES);
                end
            end
            STEP_DEC: begin
                if (range_en && pos == lo_bound) begin
                    pos_nxt       = hi_bound;
                    raw_evt.under = 1'b1;
                end else begin
                    pos_nxt       = pos - ONE;
                    raw_evt.under = (pos == '0);
                end
            end
            default: ;
        endcase
    end

    // A trigger clear in the same cycle suppresses the step and its wrap event
    assign evt = clr ? '0 : raw_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            delta  <= '0;
            dir_up <= 1'b0;
        end else if (clr) begin
            pos   <= '0;
            delta <= '0;
        end else if (step == STEP_INC) begin
            pos    <= pos_nxt;
            delta  <= delta + ONE;
            dir_up <= 1'b1;
        end else if (step == STEP_DEC) begin
            pos    <= pos_nxt;
            delta  <= delta - ONE;
            dir_up <= 1'b0;
        end
    end

endmodule

// File: rtl/wrap_flags.sv
module wrap_flags
    import enc_pos_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wrap_evt_t           evt,
    input  logic [NUM_WRAP-1:0] clr_w1c,
    input  logic [NUM_WRAP-1:0] ie,
    input  logic                index_irq,
    output logic [NUM_WRAP-1:0] flags,
    output logic                irq
);
    logic [NUM_WRAP-1:0] set_v;

    assign set_v[WRAP_OVER]  = evt.over;
    assign set_v[WRAP_UNDER] = evt.under;

    genvar i;
    generate
        for (i = 0; i < NUM_WRAP; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    flags[i] <= 1'b0;
                else if (set_v[i])
                    flags[i] <= 1'b1;   // a new event beats a same-cycle clear
                else if (clr_w1c[i])
                    flags[i] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |(flags & ie) | index_irq;

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
    import enc_pos_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_up,
    input  logic             cnt_dn,
    input  logic             range_en,
    input  logic [POS_W-1:0] lo_bound,
    input  logic [POS_W-1:0] hi_bound,
    input  logic             trig_clr_en,
    input  logic             trig_in,
    input  logic             over_ie,
    input  logic             under_ie,
    input  logic             over_clr,
    input  logic             under_clr,
    input  logic             index_irq,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_delta,
    output logic             dir_up,
    output logic             over_flag,
    output logic             under_flag,
    output logic             irq
);
    step_e               cur_step;
    logic                trig_fire;
    wrap_evt_t           wrap_evt;
    logic [NUM_WRAP-1:0] flag_vec;
    logic [NUM_WRAP-1:0] clr_vec;
    logic [NUM_WRAP-1:0] ie_vec;

    assign cur_step = decode_step(cnt_up, cnt_dn);

    trig_edge_sync #(.STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .async_in (trig_in),
        .enable   (trig_clr_en),
        .fire     (trig_fire)
    );

    pos_core #(.POS_W(POS_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .step     (cur_step),
        .clr      (trig_fire),
        .range_en (range_en),
        .lo_bound (lo_bound),
        .hi_bound (hi_bound),
        .pos      (pos),
        .delta    (pos_delta),
        .dir_up   (dir_up),
        .evt      (wrap_evt)
    );

    assign clr_vec[WRAP_OVER]  = over_clr;
    assign clr_vec[WRAP_UNDER] = under_clr;
    assign ie_vec[WRAP_OVER]   = over_ie;
    assign ie_vec[WRAP_UNDER]  = under_ie;

    wrap_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (wrap_evt),
        .clr_w1c   (clr_vec),
        .ie        (ie_vec),
        .index_irq (index_irq),
        .flags     (flag_vec),
        .irq       (irq)
    );

    assign over_flag  = flag_vec[WRAP_OVER];
    assign under_flag = flag_vec[WRAP_UNDER];

endmodule

// File: rtl/enc_pos_checker.sv
module enc_pos_checker
    import enc_pos_pkg::*;
#(
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_up,
    input logic             cnt_dn,
    input logic             range_en,
    input logic [POS_W-1:0] lo_bound,
    input logic [POS_W-1:0] hi_bound,
    input logic             over_clr,
    input logic             under_clr,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] pos_delta,
    input logic             dir_up,
    input logic             over_flag,
    input logic             under_flag,
    input step_e            cur_step,
    input logic             trig_fire
);
    localparam logic [POS_W-1:0] ALL_ONES = {POS_W{1'b1}};

    a_r1_range_up_reload: assert property (@(posedge clk) disable iff (rst)
        (!trig_fire && cur_step == STEP_INC && range_en && pos == hi_bound)
        |=> pos == $past(lo_bound));

    a_r2_range_down_reload: assert property (@(posedge clk) disable iff (rst)
        (!trig_fire && cur_step == STEP_DEC && range_en && pos == lo_bound)
        |=> pos == $past(hi_bound));

    a_r3_free_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (!trig_fire && cur_step == STEP_INC && !range_en && pos == ALL_ONES)
        |=> pos == '0);

    a_r4_over_sticky: assert property (@(posedge clk) disable iff (rst)
        (over_flag && !over_clr) |=> over_flag);

    a_r5_under_sticky: assert property (@(posedge clk) disable iff (rst)
        (under_flag && !under_clr) |=> under_flag);

    a_r8_cancel_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_up && cnt_dn && !trig_fire)
        |=> ($stable(pos) && $stable(dir_up) && $stable(pos_delta)));

    a_r9_trigger_clears: assert property (@(posedge clk) disable iff (rst)
        trig_fire |=> (pos == '0 && pos_delta == '0));

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (!trig_fire && cur_step == STEP_DEC && !range_en && pos == '0 && under_clr)
        |=> under_flag);

endmodule

bind enc_pos_counter enc_pos_checker #(.POS_W(POS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_up     (cnt_up),
    .cnt_dn     (cnt_dn),
    .range_en   (range_en),
    .lo_bound   (lo_bound),
    .hi_bound   (hi_bound),
    .over_clr   (over_clr),
    .under_clr  (under_clr),
    .pos        (pos),
    .pos_delta  (pos_delta),
    .dir_up     (dir_up),
    .over_flag  (over_flag),
    .under_flag (under_flag),
    .cur_step   (cur_step),
    .trig_fire  (trig_fire)
);

// File: tb/sim_enc_pos_counter.sv
`timescale 1ns/100ps
module sim_enc_pos_counter;
    logic        clk = 1'b0;
    logic        rst;
    logic        cnt_up = 0, cnt_dn = 0, range_en = 0;
    logic [31:0] lo_bound = 0, hi_bound = 0;
    logic        trig_clr_en = 0, trig_in = 0;
    logic        over_ie = 0, under_ie = 0, over_clr = 0, under_clr = 0, index_irq = 0;
    logic [31:0] pos, pos_delta;
    logic        dir_up, over_flag, under_flag, irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_delta = 0;

    always #2.5 clk = ~clk;

    enc_pos_counter u0 (
        .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .range_en(range_en),
        .lo_bound(lo_bound), .hi_bound(hi_bound), .trig_clr_en(trig_clr_en),
        .trig_in(trig_in), .over_ie(over_ie), .under_ie(under_ie),
        .over_clr(over_clr), .under_clr(under_clr), .index_irq(index_irq),
        .pos(pos), .pos_delta(pos_delta), .dir_up(dir_up),
        .over_flag(over_flag), .under_flag(under_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply strobes from one falling edge to the next; results are readable on return
    task automatic do_step(input logic u, input logic d, input logic c_ov, input logic c_un);
        cnt_up = u; cnt_dn = d; over_clr = c_ov; under_clr = c_un;
        @(posedge clk);
        @(negedge clk);
        cnt_up = 0; cnt_dn = 0; over_clr = 0; under_clr = 0;
        if (u && !d) exp_delta = exp_delta + 1;
        if (d && !u) exp_delta = exp_delta - 1;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R12 pos", pos, 0);
        check("R12 delta", pos_delta, 0);
        check("R12 dir", {31'd0, dir_up}, 0);
        check("R12 flags", {30'd0, over_flag, under_flag}, 0);
        check("R6 irq idle", {31'd0, irq}, 0);
    endtask

    task automatic t_free_wrap();
        range_en = 0; lo_bound = 32'd3; hi_bound = 32'd7;   // bounds must be ignored
        do_step(0, 1, 0, 0);
        check("R3 down wrap", pos, 32'hFFFF_FFFF);
        check("R5 under set", {31'd0, under_flag}, 1);
        check("R7 dir down", {31'd0, dir_up}, 0);
        check("R11 delta -1", pos_delta, exp_delta);
        check("R6 irq masked", {31'd0, irq}, 0);
        do_step(1, 0, 0, 0);
        check("R3 up wrap", pos, 0);
        check("R4 over set", {31'd0, over_flag}, 1);
        check("R7 dir up", {31'd0, dir_up}, 1);
        check("R11 delta 0", pos_delta, exp_delta);
        over_ie = 1; #0.1;
        check("R6 irq over", {31'd0, irq}, 1);
        do_step(0, 0, 1, 0);
        check("R4 over cleared", {31'd0, over_flag}, 0);
        check("R4 under kept", {31'd0, under_flag}, 1);
        check("R6 irq after clear", {31'd0, irq}, 0);
        under_ie = 1; #0.1;
        check("R6 irq under", {31'd0, irq}, 1);
        do_step(0, 0, 0, 1);
        check("R5 under cleared", {31'd0, under_flag}, 0);
        index_irq = 1; #0.1;
        check("R6 irq index", {31'd0, irq}, 1);
        index_irq = 0; over_ie = 0; under_ie = 0;
    endtask

    task automatic t_cancel();
        do_step(1, 0, 0, 0);
        do_step(1, 1, 0, 0);
        check("R8 pos hold", pos, 1);
        check("R8 dir hold", {31'd0, dir_up}, 1);
        check("R8 delta hold", pos_delta, exp_delta);
        do_step(0, 1, 0, 0);
    endtask

    task automatic t_set_wins();
        do_step(0, 1, 0, 1);
        check("R10 under set wins", {31'd0, under_flag}, 1);
        do_step(1, 0, 1, 0);
        check("R10 over set wins", {31'd0, over_flag}, 1);
        do_step(0, 0, 1, 1);
        check("R10 flags cleared", {30'd0, over_flag, under_flag}, 0);
    endtask

    task automatic t_range();
        range_en = 1; lo_bound = 32'd5; hi_bound = 32'd9;
        for (int k = 0; k < 9; k++) do_step(1, 0, 0, 0);
        check("R1 reach bound", pos, 9);
        check("R4 no early over", {31'd0, over_flag}, 0);
        do_step(1, 0, 0, 0);
        check("R1 reload low", pos, 5);
        check("R4 over on reload", {31'd0, over_flag}, 1);
        do_step(0, 1, 0, 0);
        check("R2 reload high", pos, 9);
        check("R5 under on reload", {31'd0, under_flag}, 1);
        do_step(0, 1, 0, 0);
        check("R2 plain down", pos, 8);
        check("R11 delta range", pos_delta, exp_delta);
        do_step(0, 0, 1, 1);
        range_en = 0;
    endtask

    task automatic t_trig_off();
        trig_clr_en = 0;
        trig_in = 1;
        repeat (5) @(negedge clk);
        trig_in = 0;
        repeat (4) @(negedge clk);
        check("R9 disabled pos", pos, 8);
        check("R9 disabled delta", pos_delta, exp_delta);
    endtask

    task automatic t_trig_on();
        trig_clr_en = 1;
        cnt_up = 1; trig_in = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 not yet cleared", pos, 10);
        @(posedge clk); @(negedge clk);
        cnt_up = 0;
        check("R9 clear wins pos", pos, 0);
        check("R9 clear delta", pos_delta, 0);
        exp_delta = 0;
        do_step(1, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R9 held level no reclear", pos, 1);
        check("R11 delta after clear", pos_delta, exp_delta);
        trig_in = 0;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1;
        @(negedge clk);
        t_reset();
        t_free_wrap();
        t_cancel();
        t_set_wins();
        t_range();
        t_trig_off();
        t_trig_on();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule